// File: doc/BRIEF.md
# Memory Bandwidth Usage Monitor

This block is a single bandwidth usage monitor. It watches a stream of transfer beats. Each beat carries a byte count, a partition identifier and a performance-group tag. When the monitor is enabled and the beat passes the optional filters, the block adds the beat's bytes to an internal total. Software reads that total through a counter register. The visible value is either the raw byte total or the total shifted right by a fixed scale.

A capture register keeps a snapshot of the counter and of a not-ready flag. A snapshot is taken on a selected external capture event, or on overflow when that option is enabled. Overflow has several possible effects: the counter wraps or freezes, a sticky status bit is set, and an interrupt pulse can be raised. A capture event can be configured to perform the overflow actions in place of a plain capture.

Software reaches everything through a small word-addressed register port. A read returns the value one clock after the address is presented. The four words are:
- control (0)
- filter (1)
- counter (2)
- capture (3)

Top module: `bwmon_unit`

## Requirements
- R1: When control bit 8 (enable) is 0, beats never change the counter.
- R2: When control bit 9 is 1, only beats whose partition ID equals filter bits [15:0] are counted; when it is 0 every partition ID counts.
- R3: When control bit 10 is 1, only beats whose group tag equals filter bits [23:16] are counted; this filter is independent of the partition filter.
- R4: When control bit 11 is 1, counter bits [30:0] read the byte total shifted right by SCALE; when it is 0 they read the raw total.
- R5: Control bits [20:18] select the capture source: value k in 1..NEVT selects capt_evt[k-1], while 0 and 7 select nothing. A selected event copies {not_ready, counter value} into the capture word (bit 31 = not-ready flag).
- R6: When control bit 12 is 1, every capture clears the counter to zero right after the copy.
- R7: An overflow sets control bit 17. The bit stays set until software writes it to 0 or writes the counter register.
- R8: With control bit 13 clear, the counter wraps modulo 2^31 on overflow.
- R9: With control bit 13 set, the counter freezes on overflow at its wrapped value, so an overflow by 1 freezes at 0. A counter write releases the freeze.
- R10: When control bit 14 is 1, an overflow also captures the post-overflow value. Capture-reset still applies to that capture.
- R11: When control bit 15 is 1, a selected capture event performs the overflow actions (status set, plus the capture/freeze/reset actions that are enabled) in place of a plain capture.
- R12: ovf_irq pulses high for one cycle, the cycle after an overflow, only if control bit 16 is 1.
- R13: Control bits [7:0] always read 0x42 and ignore writes.
- R14: A counter write and a counted beat in the same cycle: the write value is kept and the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| beat_valid | input | 1 | A transfer beat is present |
| beat_bytes | input | BYTES_W | Bytes moved by the beat |
| beat_part | input | PART_W | Partition ID of the beat |
| beat_grp | input | GRP_W | Performance-group tag of the beat |
| capt_evt | input | NEVT | One-cycle external capture events |
| not_ready | input | 1 | Not-ready flag reported with the counter |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
The byte total and the freeze flag are internal state, so faults in them reach the ports only through the counter and capture words. A wrong total shows up on the first counter read after the faulty beat. A stuck freeze flag shows up only after a later beat or a counter write. A status bit that is set or cleared wrongly shows up in control bit 17 on the next control read. An interrupt fault shows up in the single cycle after the overflow.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int DATA_W = 32;
  localparam logic [7:0] TYPE_CODE = 8'h42;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FILT = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_CAPT = 2'd3;

  localparam int B_EN   = 8;
  localparam int B_MP   = 9;
  localparam int B_MG   = 10;
  localparam int B_SC   = 11;
  localparam int B_CR   = 12;
  localparam int B_FRZ  = 13;
  localparam int B_OC   = 14;
  localparam int B_CO   = 15;
  localparam int B_IE   = 16;
  localparam int B_ST   = 17;
  localparam int B_SEL  = 18;
  localparam int FILT_GRP_LSB = 16;

  typedef struct packed {
    logic [2:0] evt_sel;
    logic       irq_en;
    logic       cevt_ovf;
    logic       ovf_capt;
    logic       frz;
    logic       capt_rst;
    logic       scale;
    logic       match_grp;
    logic       match_part;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/bwmon_evsel.sv
module bwmon_evsel #(
  parameter int NEVT = 6
) (
  input  logic [NEVT-1:0] evt,
  input  logic [2:0]      sel,
  output logic            hit
);
  logic [NEVT-1:0] per_src;

  for (genvar i = 0; i < NEVT; i++) begin : g_src
    assign per_src[i] = evt[i] && (sel == 3'(i + 1));
  end

  assign hit = |per_src;
endmodule

// File: rtl/bwmon_match.sv
module bwmon_match #(
  parameter int PART_W = 8,
  parameter int GRP_W  = 4
) (
  input  logic              valid,
  input  logic              en,
  input  logic              use_part,
  input  logic              use_grp,
  input  logic [PART_W-1:0] part,
  input  logic [GRP_W-1:0]  grp,
  input  logic [PART_W-1:0] want_part,
  input  logic [GRP_W-1:0]  want_grp,
  output logic              take
);
  logic part_ok, grp_ok;

  assign part_ok = !use_part || (part == want_part);
  assign grp_ok  = !use_grp  || (grp == want_grp);
  assign take    = valid && en && part_ok && grp_ok;
endmodule

// File: rtl/bwmon_count.sv
module bwmon_count
  import bwmon_pkg::*;
#(
  parameter int BYTES_W = 8,
  parameter int SCALE   = 2,
  parameter int VAL_W   = 31,
  localparam int ACC_W  = VAL_W + SCALE
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_t               ctl,
  input  logic               cnt_we,
  input  logic [VAL_W-1:0]   cnt_wval,
  input  logic               take,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               evt_hit,
  input  logic               nrdy,
  output logic [ACC_W-1:0]   acc,
  output logic               frozen,
  output logic [VAL_W-1:0]   view,
  output logic [VAL_W:0]     capt_word,
  output logic               ovf_set,
  output logic               irq
);
  logic [ACC_W:0]     sum;
  logic               inc, nat_ovf, plain_cap, do_cap, do_clr, do_frz;
  logic [ACC_W-1:0]   inc_acc, nxt_acc, load_acc;
  logic [VAL_W-1:0]   nxt_view;

  function automatic logic [VAL_W-1:0] vis(input logic [ACC_W-1:0] a, input logic sc);
    return sc ? a[ACC_W-1:SCALE] : a[VAL_W-1:0];
  endfunction

  assign inc      = take && !frozen && !cnt_we;
  assign sum      = {1'b0, acc} + {{(ACC_W + 1 - BYTES_W){1'b0}}, bytes};
  assign nat_ovf  = inc && (ctl.scale ? sum[ACC_W] : sum[VAL_W]);
  assign inc_acc  = ctl.scale ? sum[ACC_W-1:0] : {{SCALE{1'b0}}, sum[VAL_W-1:0]};
  assign nxt_acc  = inc ? inc_acc : acc;
  assign nxt_view = vis(nxt_acc, ctl.scale);
  assign load_acc = ctl.scale ? {cnt_wval, {SCALE{1'b0}}} : {{SCALE{1'b0}}, cnt_wval};

  assign ovf_set   = nat_ovf || (evt_hit && ctl.cevt_ovf);
  assign plain_cap = evt_hit && !ctl.cevt_ovf;
  assign do_cap    = plain_cap || (ovf_set && ctl.ovf_capt);
  assign do_clr    = do_cap && ctl.capt_rst;
  assign do_frz    = ovf_set && ctl.frz;
  assign view      = vis(acc, ctl.scale);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      frozen    <= 1'b0;
      capt_word <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ovf_set && ctl.irq_en;
      if (do_cap) capt_word <= {nrdy, nxt_view};
      if (cnt_we) begin
        acc    <= load_acc;
        frozen <= 1'b0;
      end else begin
        acc <= do_clr ? '0 : nxt_acc;
        if (do_frz) frozen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwmon_regs.sv
module bwmon_regs
  import bwmon_pkg::*;
#(
  parameter int PART_W = 8,
  parameter int GRP_W  = 4,
  parameter int VAL_W  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_set,
  input  logic [VAL_W-1:0]  view,
  input  logic              nrdy,
  input  logic [VAL_W:0]    capt_word,
  output ctl_t              ctl,
  output logic              status,
  output logic [PART_W-1:0] want_part,
  output logic [GRP_W-1:0]  want_grp,
  output logic              cnt_we,
  output logic              ctrl_we,
  output logic [DATA_W-1:0] rdata
);
  logic              filt_we;
  logic [DATA_W-1:0] ctrl_word, filt_word, rd_mux;

  assign ctrl_we = we && (addr == A_CTRL);
  assign filt_we = we && (addr == A_FILT);
  assign cnt_we  = we && (addr == A_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      status    <= 1'b0;
      want_part <= '0;
      want_grp  <= '0;
      rdata     <= '0;
    end else begin
      rdata <= rd_mux;
      if (ctrl_we) begin
        ctl.en         <= wdata[B_EN];
        ctl.match_part <= wdata[B_MP];
        ctl.match_grp  <= wdata[B_MG];
        ctl.scale      <= wdata[B_SC];
        ctl.capt_rst   <= wdata[B_CR];
        ctl.frz        <= wdata[B_FRZ];
        ctl.ovf_capt   <= wdata[B_OC];
        ctl.cevt_ovf   <= wdata[B_CO];
        ctl.irq_en     <= wdata[B_IE];
        ctl.evt_sel    <= wdata[B_SEL+:3];
      end
      if (filt_we) begin
        want_part <= wdata[PART_W-1:0];
        want_grp  <= wdata[FILT_GRP_LSB+:GRP_W];
      end
      if (ovf_set)      status <= 1'b1;
      else if (ctrl_we) status <= wdata[B_ST];
      else if (cnt_we)  status <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[7:0]       = TYPE_CODE;
    ctrl_word[B_EN]      = ctl.en;
    ctrl_word[B_MP]      = ctl.match_part;
    ctrl_word[B_MG]      = ctl.match_grp;
    ctrl_word[B_SC]      = ctl.scale;
    ctrl_word[B_CR]      = ctl.capt_rst;
    ctrl_word[B_FRZ]     = ctl.frz;
    ctrl_word[B_OC]      = ctl.ovf_capt;
    ctrl_word[B_CO]      = ctl.cevt_ovf;
    ctrl_word[B_IE]      = ctl.irq_en;
    ctrl_word[B_ST]      = status;
    ctrl_word[B_SEL+:3]  = ctl.evt_sel;
    filt_word = '0;
    filt_word[PART_W-1:0]           = want_part;
    filt_word[FILT_GRP_LSB+:GRP_W]  = want_grp;
    unique case (addr)
      A_CTRL:  rd_mux = ctrl_word;
      A_FILT:  rd_mux = filt_word;
      A_CNT:   rd_mux = {nrdy, view};
      default: rd_mux = capt_word;
    endcase
  end
endmodule

// File: rtl/bwmon_unit.sv
module bwmon_unit
  import bwmon_pkg::*;
#(
  parameter int BYTES_W = 8,
  parameter int PART_W  = 8,
  parameter int GRP_W   = 4,
  parameter int NEVT    = 6,
  parameter int SCALE   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               beat_valid,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic [PART_W-1:0]  beat_part,
  input  logic [GRP_W-1:0]   beat_grp,
  input  logic [NEVT-1:0]    capt_evt,
  input  logic               not_ready,
  output logic               ovf_irq
);
  localparam int VAL_W = DATA_W - 1;
  localparam int ACC_W = VAL_W + SCALE;

  ctl_t              ctl;
  logic              status, cnt_we, ctrl_we, take, evt_hit, ovf_set, frozen;
  logic [PART_W-1:0] want_part;
  logic [GRP_W-1:0]  want_grp;
  logic [ACC_W-1:0]  acc;
  logic [VAL_W-1:0]  view;
  logic [VAL_W:0]    capt_word;

  bwmon_regs #(.PART_W(PART_W), .GRP_W(GRP_W), .VAL_W(VAL_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ovf_set(ovf_set), .view(view), .nrdy(not_ready), .capt_word(capt_word),
    .ctl(ctl), .status(status), .want_part(want_part), .want_grp(want_grp),
    .cnt_we(cnt_we), .ctrl_we(ctrl_we), .rdata(reg_rdata)
  );

  bwmon_match #(.PART_W(PART_W), .GRP_W(GRP_W)) u_match (
    .valid(beat_valid), .en(ctl.en), .use_part(ctl.match_part),
    .use_grp(ctl.match_grp), .part(beat_part), .grp(beat_grp),
    .want_part(want_part), .want_grp(want_grp), .take(take)
  );

  bwmon_evsel #(.NEVT(NEVT)) u_evsel (
    .evt(capt_evt), .sel(ctl.evt_sel), .hit(evt_hit)
  );

  bwmon_count #(.BYTES_W(BYTES_W), .SCALE(SCALE), .VAL_W(VAL_W)) u_count (
    .clk(clk), .rst(rst), .ctl(ctl), .cnt_we(cnt_we),
    .cnt_wval(reg_wdata[VAL_W-1:0]), .take(take), .bytes(beat_bytes),
    .evt_hit(evt_hit), .nrdy(not_ready), .acc(acc), .frozen(frozen),
    .view(view), .capt_word(capt_word), .ovf_set(ovf_set), .irq(ovf_irq)
  );
endmodule

// File: rtl/bwmon_unit_chk.sv
module bwmon_unit_chk
  import bwmon_pkg::*;
#(
  parameter int ACC_W = 33
) (
  input logic             clk,
  input logic             rst,
  input ctl_t             ctl,
  input logic             status,
  input logic             frozen,
  input logic [ACC_W-1:0] acc,
  input logic             cnt_we,
  input logic             ctrl_we,
  input logic             evt_hit,
  input logic             ovf_irq,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_rdata
);
  logic rd_ctrl_q;
  always_ff @(posedge clk) begin
    if (rst) rd_ctrl_q <= 1'b0;
    else     rd_ctrl_q <= (reg_addr == A_CTRL);
  end

  a_r1_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl.en && !cnt_we && !evt_hit) |=> $stable(acc));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (status && !ctrl_we && !cnt_we) |=> status);

  a_r9_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (frozen && !cnt_we && !evt_hit) |=> $stable(acc));

  a_r11_event_sets_status: assert property (@(posedge clk) disable iff (rst)
    (evt_hit && ctl.cevt_ovf) |=> status);

  a_r12_irq_gated: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> $past(ctl.irq_en));

  a_r13_type_code: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl_q |-> (reg_rdata[7:0] == TYPE_CODE));
endmodule

bind bwmon_unit bwmon_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .ctl(ctl), .status(status), .frozen(frozen),
  .acc(acc), .cnt_we(cnt_we), .ctrl_we(ctrl_we), .evt_hit(evt_hit),
  .ovf_irq(ovf_irq), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/bwmon_unit_bench.sv
module bwmon_unit_bench;
  localparam int BYTES_W = 8;
  localparam int PART_W  = 8;
  localparam int GRP_W   = 4;
  localparam int NEVT    = 6;

  localparam logic [31:0] EN  = 32'h1 << 8;
  localparam logic [31:0] MP  = 32'h1 << 9;
  localparam logic [31:0] MG  = 32'h1 << 10;
  localparam logic [31:0] SC  = 32'h1 << 11;
  localparam logic [31:0] CR  = 32'h1 << 12;
  localparam logic [31:0] FZ  = 32'h1 << 13;
  localparam logic [31:0] OC  = 32'h1 << 14;
  localparam logic [31:0] CO  = 32'h1 << 15;
  localparam logic [31:0] IE  = 32'h1 << 16;
  localparam logic [31:0] ST  = 32'h1 << 17;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic beat_valid = 1'b0;
  logic [BYTES_W-1:0] beat_bytes = '0;
  logic [PART_W-1:0] beat_part = '0;
  logic [GRP_W-1:0] beat_grp = '0;
  logic [NEVT-1:0] capt_evt = '0;
  logic not_ready = 1'b0;
  logic ovf_irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  logic rd_flag = 1'b0;
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  bwmon_unit #(.BYTES_W(BYTES_W), .PART_W(PART_W), .GRP_W(GRP_W), .NEVT(NEVT), .SCALE(2))
    u_bwmon_unit (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
      .beat_bytes(beat_bytes), .beat_part(beat_part), .beat_grp(beat_grp),
      .capt_evt(capt_evt), .not_ready(not_ready), .ovf_irq(ovf_irq));

  // monitor: pops expected read results and compares them
  always @(posedge clk) rd_seen <= rd_flag;

  always @(negedge clk) begin
    if (rd_seen) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic logic [31:0] m = msk_q.pop_front();
        automatic string t = tag_q.pop_front();
        if ((reg_rdata & m) !== (e & m)) begin
          nfail++;
          $display("FAIL %s: actual %h expected %h (mask %h)", t, reg_rdata & m, e & m, m);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
    reg_addr = a;
    rd_flag  = 1'b1;
    exp_q.push_back(e);
    msk_q.push_back(m);
    tag_q.push_back(t);
    @(negedge clk);
    rd_flag = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic beat(input int b, input int p, input int g);
    beat_valid = 1'b1; beat_bytes = BYTES_W'(b);
    beat_part = PART_W'(p); beat_grp = GRP_W'(g);
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic pulse(input logic [NEVT-1:0] v);
    capt_evt = v;
    @(negedge clk);
    capt_evt = '0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    nchk++;
    if (act !== e) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state and R13 type code
    rd(2'd0, 32'h0000_0042, ALL, "R13 reset control");
    rd(2'd2, 32'h0, ALL, "reset counter");
    rd(2'd3, 32'h0, ALL, "reset capture");
    chk(ovf_irq, 1'b0, "R12 reset irq");
    wr(2'd0, 32'h0000_00FF);
    rd(2'd0, 32'h0000_0042, 32'h0000_00FF, "R13 type ignores write");

    // R1 disabled
    wr(2'd0, 32'h0);
    beat(5, 0, 0); beat(5, 1, 1); beat(5, 2, 2);
    rd(2'd2, 32'h0, ALL, "R1 disabled no count");

    // R2 partition filter
    wr(2'd0, EN);
    beat(10, 1, 1); beat(20, 1, 1);
    rd(2'd2, 32'd30, ALL, "R2 unfiltered count");
    wr(2'd1, (32'd2 << 16) | 32'd3);
    wr(2'd0, EN | MP);
    beat(7, 3, 9); beat(100, 4, 2);
    rd(2'd2, 32'd37, ALL, "R2 partition match");

    // R3 group filter
    wr(2'd0, EN | MG);
    beat(1, 8, 2); beat(50, 3, 5);
    rd(2'd2, 32'd38, ALL, "R3 group match");

    // R4 scale
    wr(2'd0, EN | SC);
    wr(2'd2, 32'd0);
    beat(4, 0, 0); beat(4, 0, 0); beat(3, 0, 0);
    rd(2'd2, 32'd2, ALL, "R4 scaled view");
    wr(2'd0, EN);
    wr(2'd2, 32'd100);
    rd(2'd2, 32'd100, ALL, "R4 raw view");

    // R5 capture source selection (sel=3 -> capt_evt[2])
    wr(2'd0, EN | (32'd3 << 18));
    not_ready = 1'b1;
    pulse(6'b000010);
    rd(2'd3, 32'h0, ALL, "R5 unselected source ignored");
    pulse(6'b000100);
    rd(2'd3, 32'h8000_0064, ALL, "R5 capture with not-ready");
    not_ready = 1'b0;
    rd(2'd2, 32'd100, ALL, "R5 counter kept after capture");
    wr(2'd0, EN | (32'd7 << 18));
    pulse(6'b111111);
    rd(2'd3, 32'h8000_0064, ALL, "R5 selector 7 captures nothing");

    // R6 capture reset
    wr(2'd0, EN | CR | (32'd1 << 18));
    beat(5, 0, 0);
    pulse(6'b000001);
    rd(2'd3, 32'd105, ALL, "R6 capture value");
    rd(2'd2, 32'd0, ALL, "R6 counter cleared");

    // R8 wrap and R7 status
    wr(2'd0, EN);
    wr(2'd2, 32'h7FFF_FFFE);
    beat(3, 0, 0);
    rd(2'd2, 32'd1, ALL, "R8 wrapped value");
    rd(2'd0, ST, ST, "R7 status set");
    chk(ovf_irq, 1'b0, "R12 no irq when disabled");
    beat(1, 0, 0);
    rd(2'd0, ST, ST, "R7 status sticky");
    wr(2'd0, EN);
    rd(2'd0, 32'h0, ST, "R7 status cleared by write 0");
    wr(2'd2, 32'h7FFF_FFFF);
    beat(1, 0, 0);
    rd(2'd0, ST, ST, "R7 status set again");
    wr(2'd2, 32'd5);
    rd(2'd0, 32'h0, ST, "R7 status cleared by counter write");
    rd(2'd2, 32'd5, ALL, "R7 counter write value");

    // R9 freeze
    wr(2'd0, EN | FZ);
    wr(2'd2, 32'h7FFF_FFFF);
    beat(1, 0, 0);
    rd(2'd2, 32'd0, ALL, "R9 freeze at zero");
    beat(9, 0, 0);
    rd(2'd2, 32'd0, ALL, "R9 frozen holds");
    wr(2'd2, 32'd10);
    beat(2, 0, 0);
    rd(2'd2, 32'd12, ALL, "R9 unfrozen after write");

    // R10 capture on overflow with reset
    wr(2'd0, EN | OC | CR);
    wr(2'd2, 32'h7FFF_FFFD);
    beat(5, 0, 0);
    rd(2'd3, 32'd2, ALL, "R10 overflow capture");
    rd(2'd2, 32'd0, ALL, "R10 reset after overflow capture");

    // R11 capture event as overflow
    wr(2'd0, EN | CO | (32'd1 << 18));
    wr(2'd2, 32'd40);
    pulse(6'b000001);
    rd(2'd0, ST, ST, "R11 event sets status");
    rd(2'd3, 32'd2, ALL, "R11 no plain capture");
    rd(2'd2, 32'd40, ALL, "R11 counter kept");
    wr(2'd0, EN | CO | OC | FZ | (32'd1 << 18));
    pulse(6'b000001);
    rd(2'd3, 32'd40, ALL, "R11 overflow capture by event");
    beat(3, 0, 0);
    rd(2'd2, 32'd40, ALL, "R11 event freezes");
    wr(2'd2, 32'd0);

    // R12 interrupt
    wr(2'd0, EN | IE);
    wr(2'd2, 32'h7FFF_FFFF);
    chk(ovf_irq, 1'b0, "R12 idle irq");
    beat(1, 0, 0);
    chk(ovf_irq, 1'b1, "R12 irq pulse");
    @(negedge clk);
    chk(ovf_irq, 1'b0, "R12 irq single cycle");

    // R14 write beats beat
    wr(2'd0, EN);
    beat_valid = 1'b1; beat_bytes = 8'd9; beat_part = '0; beat_grp = '0;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd50;
    @(negedge clk);
    beat_valid = 1'b0; reg_we = 1'b0;
    rd(2'd2, 32'd50, ALL, "R14 write wins over beat");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule